// File: doc/BRIEF.md
# Engine Cycle Controller

This block paces an array of identical processing engines that all update in lockstep. A host drives it through a small register interface. The host can advance the array by exactly one update cycle, let it run freely cycle after cycle, or halt a free run. Every cycle opens with one start pulse that reaches all engines on the same clock. The cycle closes only after each engine has raised its done flag at least once. Engines may finish in different clocks, so each done flag is held until the cycle closes.

The same interface gives the host a window into each engine's local memory. The host picks an engine with a 32-bit index register and a word with an address register. It then reads or writes through a data register. These accesses go through only while no cycle is in progress. An access that arrives during a cycle, or that names an engine that does not exist, is refused. It has no effect and sets a sticky error flag. A 32-bit counter records the number of completed cycles.

Register offsets on `host_addr_i`:
- 0 command (write only). Bit 0 = step one cycle, bit 1 = start free running, bit 2 = halt.
- 1 status. Bit 0 = cycle active, bit 1 = free running, bit 2 = access refused (sticky), bit 3 = command rejected (sticky). Writing 1 to bit 2 or bit 3 clears that flag.
- 2 completed-cycle count (read only).
- 3 engine index.
- 4 local-memory word address.
- 5 local-memory data.

Other offsets read as zero. Read data appears on `host_rdata_o` one clock after the request, with `host_rvalid_o` high.

Top module: `eng_cycle_ctrl`

## Requirements
- R1: After reset, status reads 0, the cycle count reads 0 and no start pulse is driven.
- R2: A step command given while no cycle is active and the array is not free running produces exactly one start pulse. That pulse is one clock wide and is driven on every engine's start line in the same clock.
- R3: A cycle stays active until every engine has raised done at least once since its start. Done flags raised in different clocks are remembered. On completion, the cycle count rises by exactly one.
- R4: In free-running mode (command bit 1, accepted only while idle), a new start pulse follows in the clock right after each completion. The start-to-start distance is therefore the slowest engine's latency plus one clock.
- R5: A halt command (command bit 2) lets the cycle in progress finish and then issues no further start. Afterwards, the cycle count equals the number of start pulses issued and status reads 0.
- R6: A step command given while a cycle is active or while free running is ignored: no extra start pulse is issued. It sets status bit 3, which stays set until a 1 is written to it.
- R7: While idle, a write to the data register stores into the engine chosen by the index register, at the word in the address register. A read of the data register returns that engine's word.
- R8: A local-memory access while a cycle is active drives no memory strobe and leaves memory unchanged. It sets status bit 2, which stays set until a 1 is written to it.
- R9: A local-memory access with an engine index at or above the engine count is refused in the same way as in R8 (status bit 2, no strobe).
- R10: The host reads the 32-bit completed-cycle count at offset 2. The count changes only by +1 steps.
- R11: A free-run command given while a stepped cycle is active is ignored and sets status bit 3. Free-running mode does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request, one clock per access |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 3 | Register offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, valid the clock after the request |
| host_rvalid_o | output | 1 | Read data valid |
| eng_start_o | output | N_ENG | Start pulse, one bit per engine |
| eng_done_i | input | N_ENG | Done flag from each engine |
| lm_we_o | output | N_ENG | Local-memory write strobe per engine |
| lm_re_o | output | N_ENG | Local-memory read strobe per engine |
| lm_addr_o | output | LM_AW | Local-memory word address |
| lm_wdata_o | output | 32 | Local-memory write data |
| lm_rdata_i | input | N_ENG*32 | Local-memory read data, engine i in bits [32i+31:32i] |

## Verification
Several properties are checked on every clock. A start pulse is always a full broadcast, and it appears only after an idle clock or a completion. No memory strobe fires during an active cycle or for an out-of-range index. At most one engine is strobed at a time. The cycle count moves by single steps, and each completion raises it. Only the bench's scenarios can show the other behaviours. These include holding a cycle open while one engine is late, the exact restart spacing in free-running mode, and the deferred stop with no further start after a halt. They also include ignored commands that leave the start count unchanged, and refused writes that leave memory contents intact.

// File: rtl/eng_ctrl_pkg.sv
package eng_ctrl_pkg;
  localparam int unsigned HA_W = 3;
  localparam int unsigned HD_W = 32;

  typedef enum logic [HA_W-1:0] {
    RG_CMD  = 3'd0,
    RG_STAT = 3'd1,
    RG_CYC  = 3'd2,
    RG_SEL  = 3'd3,
    RG_LMA  = 3'd4,
    RG_LMD  = 3'd5
  } reg_e;

  localparam int unsigned CMD_STEP = 0;
  localparam int unsigned CMD_GO   = 1;
  localparam int unsigned CMD_HALT = 2;

  localparam int unsigned ST_BUSY    = 0;
  localparam int unsigned ST_FREE    = 1;
  localparam int unsigned ST_ACC_ERR = 2;
  localparam int unsigned ST_CMD_ERR = 3;
endpackage

// File: rtl/ecc_done_join.sv
module ecc_done_join #(
  parameter int unsigned N_ENG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             clr_i,
  input  logic [N_ENG-1:0] done_i,
  output logic             all_done_o
);
  logic [N_ENG-1:0] seen;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    logic done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                done_q <= 1'b0;
      else if (clr_i || !busy_i)  done_q <= 1'b0;
      else if (done_i[g])         done_q <= 1'b1;
    end
    assign seen[g] = done_q | done_i[g];
  end

  assign all_done_o = &seen;
endmodule

// File: rtl/ecc_seq.sv
module ecc_seq #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             all_done_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             free_o,
  output logic             done_o,
  output logic             cmd_err_o,
  output logic [CNT_W-1:0] cyc_o
);
  logic start_q, busy_q, free_q;
  logic [CNT_W-1:0] cyc_q;
  logic step_ok, go_ok, restart, start_d;

  assign done_o    = busy_q & all_done_i;
  assign step_ok   = step_i & ~busy_q & ~free_q;
  assign go_ok     = go_i & ~busy_q & ~free_q;
  // go while already free running is harmless and not flagged
  assign cmd_err_o = (step_i & ~step_ok) | (go_i & ~go_ok & ~free_q);
  // a halt landing on the completing clock must still suppress the restart
  assign restart   = done_o & free_q & ~halt_i;
  assign start_d   = step_ok | go_ok | restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      free_q  <= 1'b0;
      cyc_q   <= '0;
    end else begin
      start_q <= start_d;
      if (start_d)     busy_q <= 1'b1;
      else if (done_o) busy_q <= 1'b0;
      if (halt_i)      free_q <= 1'b0;
      else if (go_ok)  free_q <= 1'b1;
      if (done_o)      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign free_o  = free_q;
  assign cyc_o   = cyc_q;
endmodule

// File: rtl/ecc_lm_gate.sv
module ecc_lm_gate #(
  parameter int unsigned N_ENG = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
  input  logic                acc_i,
  input  logic                we_i,
  input  logic                busy_i,
  input  logic [31:0]         sel_i,
  input  logic [N_ENG*DW-1:0] rdata_i,
  output logic [N_ENG-1:0]    we_o,
  output logic [N_ENG-1:0]    re_o,
  output logic                refuse_o,
  output logic [DW-1:0]       rdata_o
);
  logic in_range, ok;
  logic [IDX_W-1:0] idx;

  assign in_range = sel_i < 32'(N_ENG);
  assign ok       = ~busy_i & in_range;
  assign refuse_o = acc_i & ~ok;
  assign idx      = sel_i[IDX_W-1:0];

  for (genvar g = 0; g < N_ENG; g++) begin : g_strb
    logic hit;
    assign hit     = acc_i & ok & (idx == IDX_W'(g));
    assign we_o[g] = hit & we_i;
    assign re_o[g] = hit & ~we_i;
  end

  assign rdata_o = ok ? rdata_i[idx*DW +: DW] : '0;
endmodule

// File: rtl/eng_cycle_ctrl.sv
module eng_cycle_ctrl
  import eng_ctrl_pkg::*;
#(
  parameter int unsigned N_ENG = 4,
  parameter int unsigned LM_AW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  host_req_i,
  input  logic                  host_we_i,
  input  logic [HA_W-1:0]       host_addr_i,
  input  logic [HD_W-1:0]       host_wdata_i,
  output logic [HD_W-1:0]       host_rdata_o,
  output logic                  host_rvalid_o,
  output logic [N_ENG-1:0]      eng_start_o,
  input  logic [N_ENG-1:0]      eng_done_i,
  output logic [N_ENG-1:0]      lm_we_o,
  output logic [N_ENG-1:0]      lm_re_o,
  output logic [LM_AW-1:0]      lm_addr_o,
  output logic [HD_W-1:0]       lm_wdata_o,
  input  logic [N_ENG*HD_W-1:0] lm_rdata_i
);
  logic wr, rd;
  logic step, go, halt;
  logic start_q, busy_q, free_q, cyc_done, cmd_rej, all_done;
  logic [HD_W-1:0] cyc_q, sel_q, lm_rd;
  logic [LM_AW-1:0] lma_q;
  logic lm_acc, lm_refuse;
  logic acc_err_q, cmd_err_q;

  assign wr   = host_req_i & host_we_i;
  assign rd   = host_req_i & ~host_we_i;
  assign step = wr & (host_addr_i == RG_CMD) & host_wdata_i[CMD_STEP];
  assign go   = wr & (host_addr_i == RG_CMD) & host_wdata_i[CMD_GO];
  assign halt = wr & (host_addr_i == RG_CMD) & host_wdata_i[CMD_HALT];
  assign lm_acc = host_req_i & (host_addr_i == RG_LMD);

  ecc_seq #(.CNT_W(HD_W)) u_seq (
    .clk_i, .rst_ni,
    .step_i(step), .go_i(go), .halt_i(halt), .all_done_i(all_done),
    .start_o(start_q), .busy_o(busy_q), .free_o(free_q),
    .done_o(cyc_done), .cmd_err_o(cmd_rej), .cyc_o(cyc_q)
  );

  ecc_done_join #(.N_ENG(N_ENG)) u_join (
    .clk_i, .rst_ni,
    .busy_i(busy_q), .clr_i(cyc_done), .done_i(eng_done_i),
    .all_done_o(all_done)
  );

  ecc_lm_gate #(.N_ENG(N_ENG), .DW(HD_W)) u_gate (
    .acc_i(lm_acc), .we_i(host_we_i), .busy_i(busy_q), .sel_i(sel_q),
    .rdata_i(lm_rdata_i), .we_o(lm_we_o), .re_o(lm_re_o),
    .refuse_o(lm_refuse), .rdata_o(lm_rd)
  );

  assign eng_start_o = {N_ENG{start_q}};
  assign lm_addr_o   = lma_q;
  assign lm_wdata_o  = host_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      lma_q     <= '0;
      acc_err_q <= 1'b0;
      cmd_err_q <= 1'b0;
    end else begin
      if (wr && host_addr_i == RG_SEL) sel_q <= host_wdata_i;
      if (wr && host_addr_i == RG_LMA) lma_q <= host_wdata_i[LM_AW-1:0];
      if (lm_refuse) acc_err_q <= 1'b1;
      else if (wr && host_addr_i == RG_STAT && host_wdata_i[ST_ACC_ERR]) acc_err_q <= 1'b0;
      if (cmd_rej) cmd_err_q <= 1'b1;
      else if (wr && host_addr_i == RG_STAT && host_wdata_i[ST_CMD_ERR]) cmd_err_q <= 1'b0;
    end
  end

  logic [HD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (host_addr_i)
      RG_STAT: begin
        rd_mux[ST_BUSY]    = busy_q;
        rd_mux[ST_FREE]    = free_q;
        rd_mux[ST_ACC_ERR] = acc_err_q;
        rd_mux[ST_CMD_ERR] = cmd_err_q;
      end
      RG_CYC:  rd_mux = cyc_q;
      RG_SEL:  rd_mux = sel_q;
      RG_LMA:  rd_mux = HD_W'(lma_q);
      RG_LMD:  rd_mux = lm_rd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o  <= '0;
      host_rvalid_o <= 1'b0;
    end else begin
      host_rvalid_o <= rd;
      if (rd) host_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/eng_cycle_ctrl_chk.sv
module eng_cycle_ctrl_chk #(
  parameter int unsigned N_ENG = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_ENG-1:0] eng_start_o,
  input logic [N_ENG-1:0] lm_we_o,
  input logic [N_ENG-1:0] lm_re_o,
  input logic             busy_q,
  input logic             cyc_done,
  input logic [31:0]      cyc_q,
  input logic [31:0]      sel_q
);
  AST_START_BROADCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_start_o) |-> (&eng_start_o)); // R2
  AST_START_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_start_o) |-> $past(!busy_q || cyc_done)); // R4
  AST_LM_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lm_we_o | lm_re_o)) |-> !busy_q); // R8
  AST_LM_ONE_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lm_we_o | lm_re_o)); // R7
  AST_LM_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lm_we_o | lm_re_o)) |-> (sel_q < 32'(N_ENG))); // R9
  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != $past(cyc_q)) |-> (cyc_q == $past(cyc_q) + 32'd1)); // R10
  AST_CNT_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_done |=> (cyc_q == $past(cyc_q) + 32'd1)); // R3
endmodule

bind eng_cycle_ctrl eng_cycle_ctrl_chk #(.N_ENG(N_ENG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eng_start_o(eng_start_o),
  .lm_we_o(lm_we_o), .lm_re_o(lm_re_o), .busy_q(busy_q),
  .cyc_done(cyc_done), .cyc_q(cyc_q), .sel_q(sel_q)
);

// File: tb/eng_cycle_ctrl_tb_top.sv
module eng_cycle_ctrl_tb_top;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wd = '0, rdata;
  logic rvalid;
  logic [N-1:0] start, done, lwe, lre;
  logic [AW-1:0] laddr;
  logic [31:0] lwd;
  logic [N*32-1:0] lrd;

  eng_cycle_ctrl #(.N_ENG(N), .LM_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we),
    .host_addr_i(addr), .host_wdata_i(wd), .host_rdata_o(rdata),
    .host_rvalid_o(rvalid), .eng_start_o(start), .eng_done_i(done),
    .lm_we_o(lwe), .lm_re_o(lre), .lm_addr_o(laddr), .lm_wdata_o(lwd),
    .lm_rdata_i(lrd)
  );

  int dly [N];
  logic hold [N];

  for (genvar g = 0; g < N; g++) begin : g_stub
    logic [7:0] cnt;
    logic [31:0] mem [1<<AW];
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (start[g]) cnt <= 8'(dly[g]);
      else if (cnt != 0 && !hold[g]) cnt <= cnt - 8'd1;
    end
    assign done[g] = (cnt == 8'd1) && !hold[g];
    always @(posedge clk) if (lwe[g]) mem[laddr] <= lwd;
    assign lrd[g*32 +: 32] = mem[laddr];
  end

  int n_chk = 0, n_fail = 0;
  int tick = 0, n_starts = 0, n_partial = 0, last_start = 0, gap = 0;
  bit finished = 0;

  always @(negedge clk) begin
    tick++;
    if (|start) begin
      n_starts++;
      if (!(&start)) n_partial++;
      gap = tick - last_start;
      last_start = tick;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic w, input logic [2:0] a, input logic [31:0] d,
                         output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      host_op(1'b0, 3'd1, 32'd0, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  typedef struct packed {
    logic chk; logic w; logic [2:0] a; logic [31:0] d; logic [31:0] e;
  } vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd3, 32'd1,          32'd0},          // sel engine 1
    '{1'b0, 1'b1, 3'd4, 32'd5,          32'd0},          // word 5
    '{1'b0, 1'b1, 3'd5, 32'hA5A5_0001,  32'd0},
    '{1'b0, 1'b1, 3'd3, 32'd3,          32'd0},
    '{1'b0, 1'b1, 3'd5, 32'h3333_0003,  32'd0},
    '{1'b1, 1'b0, 3'd5, 32'd0,          32'h3333_0003},  // R7
    '{1'b0, 1'b1, 3'd3, 32'd1,          32'd0},
    '{1'b1, 1'b0, 3'd5, 32'd0,          32'hA5A5_0001},  // R7
    '{1'b0, 1'b1, 3'd3, 32'd4,          32'd0},          // out of range
    '{1'b0, 1'b1, 3'd5, 32'h0000_DEAD,  32'd0},
    '{1'b1, 1'b0, 3'd1, 32'd0,          32'h0000_0004},  // R9
    '{1'b0, 1'b1, 3'd1, 32'h0000_000C,  32'd0},
    '{1'b1, 1'b0, 3'd1, 32'd0,          32'h0000_0000},  // R8 clear
    '{1'b1, 1'b0, 3'd2, 32'd0,          32'h0000_0000}   // R10
  };
  localparam string VTAG [NV] = '{"R7", "R7", "R7", "R7", "R7", "R7", "R7", "R7",
                                  "R9", "R9", "R9", "R8", "R8", "R10"};

  initial begin
    logic [31:0] r;
    int s0;
    for (int i = 0; i < N; i++) begin dly[i] = 1; hold[i] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    chk("R1 start", 32'(start), 32'd0);
    host_op(1'b0, 3'd1, 0, r); chk("R1 status", r, 32'd0);
    host_op(1'b0, 3'd2, 0, r); chk("R1 count", r, 32'd0);

    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i].w, VEC[i].a, VEC[i].d, r);
      if (VEC[i].chk) chk(VTAG[i], r, VEC[i].e);
    end

    // stepped cycle with one engine held late
    dly[0] = 2; dly[1] = 4; dly[2] = 3; dly[3] = 1; hold[2] = 1'b1;
    s0 = n_starts;
    host_op(1'b1, 3'd0, 32'h1, r);
    repeat (8) @(negedge clk);
    chk("R2 one start", n_starts, s0 + 1);
    host_op(1'b0, 3'd1, 0, r); chk("R3 held open", r, 32'h1);
    host_op(1'b1, 3'd0, 32'h1, r);
    host_op(1'b0, 3'd1, 0, r); chk("R6 step busy", r, 32'h9);
    chk("R6 no extra start", n_starts, s0 + 1);
    host_op(1'b1, 3'd1, 32'h8, r);
    host_op(1'b1, 3'd0, 32'h2, r);
    host_op(1'b0, 3'd1, 0, r); chk("R11 go busy", r, 32'h9);
    host_op(1'b1, 3'd3, 32'd1, r);
    host_op(1'b1, 3'd5, 32'h0BAD_0BAD, r);
    host_op(1'b0, 3'd1, 0, r); chk("R8 refused", r, 32'hD);
    host_op(1'b0, 3'd2, 0, r); chk("R3 not done", r, 32'd0);
    hold[2] = 1'b0;
    wait_idle();
    host_op(1'b0, 3'd2, 0, r); chk("R3 count", r, 32'd1);
    host_op(1'b1, 3'd1, 32'hC, r);
    host_op(1'b0, 3'd5, 0, r); chk("R8 mem kept", r, 32'hA5A5_0001);
    chk("R2 total starts", n_starts, s0 + 1);

    // free running
    for (int i = 0; i < N; i++) dly[i] = 1;
    host_op(1'b1, 3'd0, 32'h2, r);
    repeat (20) @(negedge clk);
    chk("R4 gap fast", gap, 2);
    host_op(1'b0, 3'd1, 0, r); chk("R4 free status", r, 32'h3);
    host_op(1'b1, 3'd0, 32'h1, r);
    host_op(1'b0, 3'd1, 0, r); chk("R6 step free", r, 32'hB);
    host_op(1'b1, 3'd1, 32'h8, r);
    dly[1] = 3; dly[2] = 2; dly[3] = 3;
    repeat (24) @(negedge clk);
    chk("R4 gap slow", gap, 4);
    host_op(1'b1, 3'd0, 32'h4, r);
    wait_idle();
    s0 = n_starts;
    host_op(1'b0, 3'd2, 0, r); chk("R5 count=starts", r, 32'(n_starts));
    repeat (30) @(negedge clk);
    chk("R5 no restart", n_starts, s0);
    host_op(1'b0, 3'd1, 0, r); chk("R5 status", r, 32'd0);

    host_op(1'b1, 3'd0, 32'h1, r);
    wait_idle();
    host_op(1'b0, 3'd2, 0, r); chk("R2 step after halt", r, 32'(n_starts));
    chk("R2 broadcast", n_partial, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule